// File: doc/BRIEF.md
# ECC Error Status and Capture Unit

This unit sits beside a memory controller's ECC decoder and its address-range checker. Each error class has its own tracker: out-of-range access, correctable ECC error and uncorrectable ECC error. A tracker records the first event since the last acknowledge in a sticky "single" bit and loads that event's details into capture registers. A later event of the same class only sets the class's "multiple" bit. The details are the address, plus the data word and syndrome for ECC errors. Two further sticky flags report DRAM initialization done and "an ECC event was seen".

Software works through a word-wide register port. It reads status and captures, clears all status with a single acknowledge write, masks interrupt sources and selects the ECC mode. Checking is active only in the check-and-correct mode, and the unit drives that decision out to the codec as `ecc_on`.

Each tracker is a three-state machine: `TRK_CLEAN`, `TRK_SINGLE` and `TRK_MULTI`. Its transitions are as follows:
- CLEAN→SINGLE on an event, which also loads the capture registers.
- SINGLE→MULTI on an event.
- SINGLE→CLEAN and MULTI→CLEAN on an acknowledge with no event.
- Any state→SINGLE on an acknowledge that coincides with an event, which also loads the captures.
- Otherwise the tracker holds its state.

Top module: `ecc_err_status`

## Requirements
- R1: After reset the status register reads 0, the mask register reads 0xFF, the mode register reads 0, `irq` is 0, `ecc_on` is 0 and every capture register reads 0.
- R2: With mode 3, a correctable event sets status bit 2 and bit 7 on the next clock. It also captures the event's address in offsets 6 (bits 31:0) and 7 (bit 0 = address bit 32), the data in offsets 8 (low word) and 9 (high word), and the syndrome in bits 23:16 of offset 3.
- R3: With mode 3, an uncorrectable event sets status bit 4 and bit 7. Its captures go to a separate set: address in offsets 10/11, data in offsets 12/13, and the syndrome in bits 15:8 of offset 3.
- R4: A further event of a class whose single bit is already set sets that class's multiple bit (bit 1, 3 or 5) and leaves its capture registers unchanged.
- R5: When the 2-bit mode field (offset 2, bits 1:0) is not 3, correctable and uncorrectable events change neither status nor captures. `ecc_on` is 1 exactly when the mode is 3.
- R6: An out-of-range event sets status bit 0 first and bit 1 on a repeat, whatever the mode. The first event's 33-bit address is captured in offset 4 (bits 31:0) and offset 5 (bit 0).
- R7: An initialization-done pulse sets status bit 6.
- R8: Writing exactly 0x000000FF to the status register (offset 0) clears all eight status bits on the next clock. Any other value written there has no effect.
- R9: When an acknowledge write and an event arrive in the same cycle, the event's single bit (and bit 7 for an ECC event) stays set, its multiple bit clears, and the captures load the new event.
- R10: `irq` is 1 exactly when some status bit is 1 whose mask bit (offset 1, bits 7:0, 1 = masked) is 0. Masking never changes status.
- R11: The mask and mode registers read back what was last written in their low 8 and 2 bits. Offsets above 13 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_corr_evt | input | 1 | Decoder found a correctable error this cycle |
| ecc_unc_evt | input | 1 | Decoder found an uncorrectable error this cycle |
| ecc_addr | input | 33 | Address of the decoded access |
| ecc_data | input | 64 | Data word of the decoded access |
| ecc_syn | input | 8 | Syndrome of the decoded access |
| oor_evt | input | 1 | Access outside the populated memory range |
| oor_addr | input | 33 | Address of the out-of-range access |
| init_done | input | 1 | DRAM initialization completed pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ecc_on | output | 1 | Check-and-correct enabled towards the codec |
| irq | output | 1 | Unmasked status interrupt |

## Verification
The bench first walks the directed sequence that a memory self-test performs. That sequence covers the following:
- an event with checking off, which must leave no trace;
- a lone correctable error and then a second one, which separates first-event capture from the multiple bit;
- an uncorrectable error, which must land in its own captures and in the other syndrome byte;
- a repeated out-of-range access and an initialization pulse.

Directed cases then pit a non-acknowledge write against the exact acknowledge value. An acknowledge coinciding with a fresh event tells "event wins" apart from "clear wins". Mask patterns show whether the interrupt follows only unmasked bits. A seeded random phase mixes simultaneous events of all classes with random mode, mask and acknowledge writes. It checks the interrupt and every register against a reference model after each cycle.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;

    typedef enum logic [1:0] {
        TRK_CLEAN  = 2'd0,
        TRK_SINGLE = 2'd1,
        TRK_MULTI  = 2'd2
    } trk_state_e;

    localparam int unsigned REG_AW  = 4;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned ST_W    = 8;
    localparam int unsigned N_CLASS = 3;

    // tracker index per error class
    localparam int unsigned CLS_OOR  = 0;
    localparam int unsigned CLS_CORR = 1;
    localparam int unsigned CLS_UNC  = 2;

    // register word offsets
    localparam logic [REG_AW-1:0] OFS_STATUS = 4'd0;
    localparam logic [REG_AW-1:0] OFS_MASK   = 4'd1;
    localparam logic [REG_AW-1:0] OFS_MODE   = 4'd2;
    localparam logic [REG_AW-1:0] OFS_SYN    = 4'd3;
    localparam logic [REG_AW-1:0] OFS_OA_LO  = 4'd4;
    localparam logic [REG_AW-1:0] OFS_OA_HI  = 4'd5;
    localparam logic [REG_AW-1:0] OFS_CA_LO  = 4'd6;
    localparam logic [REG_AW-1:0] OFS_CA_HI  = 4'd7;
    localparam logic [REG_AW-1:0] OFS_CD_LO  = 4'd8;
    localparam logic [REG_AW-1:0] OFS_CD_HI  = 4'd9;
    localparam logic [REG_AW-1:0] OFS_UA_LO  = 4'd10;
    localparam logic [REG_AW-1:0] OFS_UA_HI  = 4'd11;
    localparam logic [REG_AW-1:0] OFS_UD_LO  = 4'd12;
    localparam logic [REG_AW-1:0] OFS_UD_HI  = 4'd13;

    localparam logic [WORD_W-1:0] ACK_ALL  = 32'h0000_00FF;
    localparam logic [1:0]        MODE_ON  = 2'b11;
    localparam logic [ST_W-1:0]   MASK_RST = 8'hFF;

    // syndrome byte positions inside the shared syndrome word
    localparam int unsigned SYN_CORR_LSB = 16;
    localparam int unsigned SYN_UNC_LSB  = 8;

endpackage

// File: rtl/err_track_fsm.sv
module err_track_fsm
    import ecc_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic ack,
    output logic single_o,
    output logic multi_o,
    output logic load_o
);

    trk_state_e state_q;
    trk_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_CLEAN: begin
                if (evt) state_d = TRK_SINGLE;
            end
            TRK_SINGLE: begin
                if (ack)      state_d = evt ? TRK_SINGLE : TRK_CLEAN;
                else if (evt) state_d = TRK_MULTI;
            end
            TRK_MULTI: begin
                if (ack) state_d = evt ? TRK_SINGLE : TRK_CLEAN;
            end
            default: state_d = TRK_CLEAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        single_o = 1'b0;
        multi_o  = 1'b0;
        load_o   = 1'b0;
        unique case (state_q)
            TRK_CLEAN: begin
                load_o = evt;
            end
            TRK_SINGLE: begin
                single_o = 1'b1;
                load_o   = evt && ack;
            end
            TRK_MULTI: begin
                single_o = 1'b1;
                multi_o  = 1'b1;
                load_o   = evt && ack;
            end
            default: begin
                load_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cap_reg.sv
module cap_reg #(
    parameter int unsigned W = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/ecc_cfg_regs.sv
module ecc_cfg_regs
    import ecc_stat_pkg::*;
#(
    parameter int unsigned ADDR_W = 33,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned SYN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [ST_W-1:0]   status,
    input  logic [ADDR_W-1:0] oa,
    input  logic [ADDR_W-1:0] ca,
    input  logic [DATA_W-1:0] cd,
    input  logic [SYN_W-1:0]  cs,
    input  logic [ADDR_W-1:0] ua,
    input  logic [DATA_W-1:0] ud,
    input  logic [SYN_W-1:0]  us,
    output logic [ST_W-1:0]   mask_o,
    output logic [1:0]        mode_o,
    output logic              ack_o,
    output logic [WORD_W-1:0] rdata_o
);

    localparam int unsigned AHI_W = ADDR_W - WORD_W;
    localparam int unsigned DHI_W = DATA_W - WORD_W;

    logic [WORD_W-1:0] syn_word;

    assign ack_o = reg_we && (reg_addr == OFS_STATUS) && (reg_wdata == ACK_ALL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= MASK_RST;
            mode_o <= 2'b00;
        end else if (reg_we) begin
            if (reg_addr == OFS_MASK) mask_o <= reg_wdata[ST_W-1:0];
            if (reg_addr == OFS_MODE) mode_o <= reg_wdata[1:0];
        end
    end

    always_comb begin
        syn_word = '0;
        syn_word[SYN_CORR_LSB +: SYN_W] = cs;
        syn_word[SYN_UNC_LSB  +: SYN_W] = us;
    end

    always_comb begin
        rdata_o = '0;
        unique case (reg_addr)
            OFS_STATUS: rdata_o = {{(WORD_W-ST_W){1'b0}}, status};
            OFS_MASK:   rdata_o = {{(WORD_W-ST_W){1'b0}}, mask_o};
            OFS_MODE:   rdata_o = {{(WORD_W-2){1'b0}}, mode_o};
            OFS_SYN:    rdata_o = syn_word;
            OFS_OA_LO:  rdata_o = oa[WORD_W-1:0];
            OFS_OA_HI:  rdata_o = {{(WORD_W-AHI_W){1'b0}}, oa[ADDR_W-1:WORD_W]};
            OFS_CA_LO:  rdata_o = ca[WORD_W-1:0];
            OFS_CA_HI:  rdata_o = {{(WORD_W-AHI_W){1'b0}}, ca[ADDR_W-1:WORD_W]};
            OFS_CD_LO:  rdata_o = cd[WORD_W-1:0];
            OFS_CD_HI:  rdata_o = {{(WORD_W-DHI_W){1'b0}}, cd[DATA_W-1:WORD_W]};
            OFS_UA_LO:  rdata_o = ua[WORD_W-1:0];
            OFS_UA_HI:  rdata_o = {{(WORD_W-AHI_W){1'b0}}, ua[ADDR_W-1:WORD_W]};
            OFS_UD_LO:  rdata_o = ud[WORD_W-1:0];
            OFS_UD_HI:  rdata_o = {{(WORD_W-DHI_W){1'b0}}, ud[DATA_W-1:WORD_W]};
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status
    import ecc_stat_pkg::*;
#(
    parameter int unsigned ADDR_W = 33,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned SYN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_corr_evt,
    input  logic              ecc_unc_evt,
    input  logic [ADDR_W-1:0] ecc_addr,
    input  logic [DATA_W-1:0] ecc_data,
    input  logic [SYN_W-1:0]  ecc_syn,
    input  logic              oor_evt,
    input  logic [ADDR_W-1:0] oor_addr,
    input  logic              init_done,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              ecc_on,
    output logic              irq
);

    localparam int unsigned BIT_INIT = 6;
    localparam int unsigned BIT_ANY  = 7;

    logic [ST_W-1:0]    irq_mask;
    logic [1:0]         ecc_mode;
    logic               ack_all;
    logic [N_CLASS-1:0] cls_evt;
    logic [N_CLASS-1:0] cls_single;
    logic [N_CLASS-1:0] cls_multi;
    logic [N_CLASS-1:0] cls_load;
    logic               init_q;
    logic               any_q;
    logic [ST_W-1:0]    status_q;
    logic [ADDR_W-1:0]  o_addr_q;
    logic [ADDR_W-1:0]  c_addr_q;
    logic [DATA_W-1:0]  c_data_q;
    logic [SYN_W-1:0]   c_syn_q;
    logic [ADDR_W-1:0]  u_addr_q;
    logic [DATA_W-1:0]  u_data_q;
    logic [SYN_W-1:0]   u_syn_q;

    assign ecc_on = (ecc_mode == MODE_ON);

    assign cls_evt[CLS_OOR]  = oor_evt;
    assign cls_evt[CLS_CORR] = ecc_on && ecc_corr_evt;
    assign cls_evt[CLS_UNC]  = ecc_on && ecc_unc_evt;

    for (genvar g = 0; g < N_CLASS; g++) begin : g_trk
        err_track_fsm u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (cls_evt[g]),
            .ack      (ack_all),
            .single_o (cls_single[g]),
            .multi_o  (cls_multi[g]),
            .load_o   (cls_load[g])
        );
        assign status_q[2*g]   = cls_single[g];
        assign status_q[2*g+1] = cls_multi[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= 1'b0;
            any_q  <= 1'b0;
        end else begin
            init_q <= init_done || (init_q && !ack_all);
            any_q  <= cls_evt[CLS_CORR] || cls_evt[CLS_UNC] || (any_q && !ack_all);
        end
    end

    assign status_q[BIT_INIT] = init_q;
    assign status_q[BIT_ANY]  = any_q;

    cap_reg #(.W(ADDR_W)) u_cap_oa (.clk(clk), .rst_n(rst_n), .load(cls_load[CLS_OOR]),
                                    .d(oor_addr), .q(o_addr_q));
    cap_reg #(.W(ADDR_W)) u_cap_ca (.clk(clk), .rst_n(rst_n), .load(cls_load[CLS_CORR]),
                                    .d(ecc_addr), .q(c_addr_q));
    cap_reg #(.W(DATA_W)) u_cap_cd (.clk(clk), .rst_n(rst_n), .load(cls_load[CLS_CORR]),
                                    .d(ecc_data), .q(c_data_q));
    cap_reg #(.W(SYN_W))  u_cap_cs (.clk(clk), .rst_n(rst_n), .load(cls_load[CLS_CORR]),
                                    .d(ecc_syn), .q(c_syn_q));
    cap_reg #(.W(ADDR_W)) u_cap_ua (.clk(clk), .rst_n(rst_n), .load(cls_load[CLS_UNC]),
                                    .d(ecc_addr), .q(u_addr_q));
    cap_reg #(.W(DATA_W)) u_cap_ud (.clk(clk), .rst_n(rst_n), .load(cls_load[CLS_UNC]),
                                    .d(ecc_data), .q(u_data_q));
    cap_reg #(.W(SYN_W))  u_cap_us (.clk(clk), .rst_n(rst_n), .load(cls_load[CLS_UNC]),
                                    .d(ecc_syn), .q(u_syn_q));

    ecc_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYN_W(SYN_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status    (status_q),
        .oa        (o_addr_q),
        .ca        (c_addr_q),
        .cd        (c_data_q),
        .cs        (c_syn_q),
        .ua        (u_addr_q),
        .ud        (u_data_q),
        .us        (u_syn_q),
        .mask_o    (irq_mask),
        .mode_o    (ecc_mode),
        .ack_o     (ack_all),
        .rdata_o   (reg_rdata)
    );

    assign irq = |(status_q & ~irq_mask);

endmodule

// File: rtl/ecc_err_status_chk.sv
module ecc_err_status_chk #(
    parameter int unsigned ADDR_W = 33,
    parameter int unsigned SYN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        status,
    input logic [7:0]        mask,
    input logic              ecc_on,
    input logic              irq,
    input logic              ack,
    input logic              corr_evt,
    input logic              unc_evt,
    input logic              oor_evt,
    input logic              init_evt,
    input logic [SYN_W-1:0]  evt_syn,
    input logic [SYN_W-1:0]  c_syn,
    input logic [ADDR_W-1:0] c_addr
);

    // R2: first correctable event loads its syndrome
    p_first_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_on && corr_evt && !status[2]) |=> (status[2] && c_syn == $past(evt_syn)));

    // R4: repeated correctable event sets multiple bit, capture held
    p_multi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_on && corr_evt && status[2] && !ack) |=> (status[3] && $stable(c_addr)));

    // R5: with checking off, ECC single bits cannot rise
    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_on && !status[2] && !status[4]) |=> (!status[2] && !status[4]));

    // R8: acknowledge with no new event empties status
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !corr_evt && !unc_evt && !oor_evt && !init_evt) |=> (status == 8'h00));

    // R9: event coinciding with acknowledge survives as a first event
    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ecc_on && corr_evt) |=> (status[2] && !status[3] && status[7]));

    // R10: fully masked means no interrupt
    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 8'hFF) |-> !irq);

endmodule

bind ecc_err_status ecc_err_status_chk #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .status   (status_q),
    .mask     (irq_mask),
    .ecc_on   (ecc_on),
    .irq      (irq),
    .ack      (ack_all),
    .corr_evt (ecc_corr_evt),
    .unc_evt  (ecc_unc_evt),
    .oor_evt  (oor_evt),
    .init_evt (init_done),
    .evt_syn  (ecc_syn),
    .c_syn    (c_syn_q),
    .c_addr   (c_addr_q)
);

// File: tb/ecc_err_status_tb_top.sv
`timescale 1ns/1ps
module ecc_err_status_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_corr_evt = 1'b0;
    logic        ecc_unc_evt = 1'b0;
    logic [32:0] ecc_addr = '0;
    logic [63:0] ecc_data = '0;
    logic [7:0]  ecc_syn = '0;
    logic        oor_evt = 1'b0;
    logic [32:0] oor_addr = '0;
    logic        init_done = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ecc_on;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model
    logic [7:0]  m_st = 8'h00;
    logic [7:0]  m_mask = 8'hFF;
    logic [1:0]  m_mode = 2'b00;
    logic [32:0] m_oa = '0, m_ca = '0, m_ua = '0;
    logic [63:0] m_cd = '0, m_ud = '0;
    logic [7:0]  m_cs = '0, m_us = '0;

    always #4 clk = ~clk;

    ecc_err_status dut_i (
        .clk(clk), .rst_n(rst_n),
        .ecc_corr_evt(ecc_corr_evt), .ecc_unc_evt(ecc_unc_evt),
        .ecc_addr(ecc_addr), .ecc_data(ecc_data), .ecc_syn(ecc_syn),
        .oor_evt(oor_evt), .oor_addr(oor_addr), .init_done(init_done),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ecc_on(ecc_on), .irq(irq)
    );

    function automatic logic [31:0] exp_reg(input int idx);
        logic [31:0] v;
        v = '0;
        case (idx)
            0:  v = {24'h0, m_st};
            1:  v = {24'h0, m_mask};
            2:  v = {30'h0, m_mode};
            3:  v = {8'h0, m_cs, m_us, 8'h0};
            4:  v = m_oa[31:0];
            5:  v = {31'h0, m_oa[32]};
            6:  v = m_ca[31:0];
            7:  v = {31'h0, m_ca[32]};
            8:  v = m_cd[31:0];
            9:  v = m_cd[63:32];
            10: v = m_ua[31:0];
            11: v = {31'h0, m_ua[32]};
            12: v = m_ud[31:0];
            13: v = m_ud[63:32];
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic exp_irq();
        return |(m_st & ~m_mask);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        for (int i = 0; i < 16; i++) begin
            rd(i[3:0], v);
            check($sformatf("%s reg%0d", tag, i), v, exp_reg(i));
        end
        check({tag, " irq R10"}, {31'h0, irq}, {31'h0, exp_irq()});
        check({tag, " ecc_on R5"}, {31'h0, ecc_on}, {31'h0, (m_mode == 2'b11)});
    endtask

    // model of one clock edge, from the requirements
    task automatic model_edge(input logic ce, input logic ue, input logic oe, input logic ie,
                              input logic [32:0] ea, input logic [63:0] ed, input logic [7:0] es,
                              input logic [32:0] oa, input logic we, input logic [3:0] wa,
                              input logic [31:0] wd);
        logic ack, on, c, u;
        ack = we && wa == 4'd0 && wd == 32'h0000_00FF;
        on  = (m_mode == 2'b11);
        c = ce && on;
        u = ue && on;
        if (ack) m_st[1] = 1'b0; else if (oe && m_st[0]) m_st[1] = 1'b1;
        if (oe && (!m_st[0] || ack)) m_oa = oa;
        m_st[0] = oe || (m_st[0] && !ack);
        if (ack) m_st[3] = 1'b0; else if (c && m_st[2]) m_st[3] = 1'b1;
        if (c && (!m_st[2] || ack)) begin m_ca = ea; m_cd = ed; m_cs = es; end
        m_st[2] = c || (m_st[2] && !ack);
        if (ack) m_st[5] = 1'b0; else if (u && m_st[4]) m_st[5] = 1'b1;
        if (u && (!m_st[4] || ack)) begin m_ua = ea; m_ud = ed; m_us = es; end
        m_st[4] = u || (m_st[4] && !ack);
        m_st[6] = ie || (m_st[6] && !ack);
        m_st[7] = c || u || (m_st[7] && !ack);
        if (we && wa == 4'd1) m_mask = wd[7:0];
        if (we && wa == 4'd2) m_mode = wd[1:0];
    endtask

    task automatic step(input logic ce, input logic ue, input logic oe, input logic ie,
                        input logic [32:0] ea, input logic [63:0] ed, input logic [7:0] es,
                        input logic [32:0] oa, input logic we, input logic [3:0] wa,
                        input logic [31:0] wd);
        @(negedge clk);
        ecc_corr_evt = ce; ecc_unc_evt = ue; oor_evt = oe; init_done = ie;
        ecc_addr = ea; ecc_data = ed; ecc_syn = es; oor_addr = oa;
        reg_we = we; reg_addr = wa; reg_wdata = wd;
        @(posedge clk);
        model_edge(ce, ue, oe, ie, ea, ed, es, oa, we, wa, wd);
        #1;
        ecc_corr_evt = 0; ecc_unc_evt = 0; oor_evt = 0; init_done = 0; reg_we = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        step(0, 0, 0, 0, '0, '0, '0, '0, 1'b1, a, d);
    endtask

    task automatic ev(input logic ce, input logic ue, input logic oe, input logic ie,
                      input logic [32:0] ea, input logic [63:0] ed, input logic [7:0] es,
                      input logic [32:0] oa);
        step(ce, ue, oe, ie, ea, ed, es, oa, 1'b0, 4'd0, '0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(64'd200000 * 8);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2;
        check_all("R1 reset");

        // R5: checking off, events leave no trace
        ev(1, 1, 0, 0, 33'h1_0000_0040, 64'h0101_0101_0101_0101, 8'hF4, '0);
        check_all("R5 mode off");
        rd(4'd0, v); check("R5 status untouched", v, 32'h0);

        wr(4'd2, 32'h3);
        wr(4'd1, 32'h00);
        check_all("R11 cfg readback");

        // R2: lone correctable
        ev(1, 0, 0, 0, 33'h1_1234_5678, 64'h1101_0101_0101_0101, 8'hE9, '0);
        rd(4'd0, v); check("R2 status", v, 32'h84);
        check_all("R2 capture");

        // R4: second correctable, capture held
        ev(1, 0, 0, 0, 33'h0_0000_2000, 64'hDEAD_BEEF_0000_0001, 8'h0B, '0);
        rd(4'd0, v); check("R4 status", v, 32'h8C);
        rd(4'd6, v); check("R4 capture held", v, 32'h1234_5678);

        // R3: uncorrectable in its own set
        ev(0, 1, 0, 0, 33'h1_0000_0800, 64'h6101_0101_0101_0101, 8'h3C, '0);
        rd(4'd3, v); check("R3 syndrome word", v, 32'h00E9_3C00);
        check_all("R3 capture");

        // R6 and R7
        ev(0, 0, 1, 1, '0, '0, '0, 33'h1_FFFF_0000);
        ev(0, 0, 1, 0, '0, '0, '0, 33'h0_0000_0004);
        rd(4'd0, v); check("R6 R7 status", v, 32'hDF);
        rd(4'd5, v); check("R6 addr high bit", v, 32'h1);
        check_all("R6 capture");

        // R8: near-miss write ignored, exact value clears
        wr(4'd0, 32'h0000_007F);
        rd(4'd0, v); check("R8 non-ack ignored", v, 32'hDF);
        wr(4'd0, 32'h0000_01FF);
        rd(4'd0, v); check("R8 upper bits ignored", v, 32'hDF);
        wr(4'd0, 32'h0000_00FF);
        rd(4'd0, v); check("R8 ack clears", v, 32'h0);
        check_all("R8 after ack");

        // R9: ack and event together
        ev(1, 0, 0, 0, 33'h0_0000_0100, 64'h1, 8'h01, '0);
        ev(1, 0, 0, 0, 33'h0_0000_0200, 64'h2, 8'h02, '0);
        step(1, 0, 0, 0, 33'h1_AAAA_5555, 64'h3333_4444_5555_6666, 8'h80, '0,
             1'b1, 4'd0, 32'h0000_00FF);
        rd(4'd0, v); check("R9 event wins", v, 32'h84);
        rd(4'd6, v); check("R9 capture reloaded", v, 32'hAAAA_5555);
        check_all("R9");

        // R10: masking
        wr(4'd1, 32'hFF);
        check("R10 all masked", {31'h0, irq}, 32'h0);
        rd(4'd0, v); check("R10 status kept", v, 32'h84);
        wr(4'd1, 32'hFB);
        check("R10 bit2 unmasked", {31'h0, irq}, 32'h1);
        wr(4'd1, 32'h7B & 32'hFB);
        check_all("R10");

        // random phase
        for (int k = 0; k < 600; k++) begin
            logic ce, ue, oe, ie, we;
            logic [3:0]  wa;
            logic [31:0] wd;
            ce = ($urandom % 4) == 0;
            ue = ($urandom % 5) == 0;
            oe = ($urandom % 6) == 0;
            ie = ($urandom % 10) == 0;
            we = ($urandom % 4) == 0;
            wa = 4'($urandom % 3);
            wd = $urandom;
            if (wa == 4'd0 && ($urandom % 2) == 0) wd = 32'h0000_00FF;
            if (wa == 4'd2 && ($urandom % 3) != 0) wd = 32'h3;
            step(ce, ue, oe, ie, {1'($urandom), 32'($urandom)},
                 {32'($urandom), 32'($urandom)}, 8'($urandom),
                 {1'($urandom), 32'($urandom)}, we, wa, wd);
            rd(4'd0, v); check("R4 R9 random status", v, exp_reg(0));
            check("R10 random irq", {31'h0, irq}, {31'h0, exp_irq()});
            if (k % 25 == 0) check_all("R2 R3 R6 random");
        end

        finish_run();
    end

endmodule